// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a processor core and decides which interrupt the core should take next. It watches a bank of maskable peripheral interrupt lines and three system sources. The first is a non-maskable request, formed from several fault inputs ORed together. The second is a hard-fault request. The third is a supervisor-call request whose priority software can set. The block picks the single most urgent pending source and presents its exception number, together with the byte address of its vector table entry.

Software programs enables, pending flags and 2-bit priorities through a small word-addressed register bus. The core takes the presented exception with an acknowledge pulse and retires the innermost handler with a completion pulse. Handlers nest. A new request is presented only if it is strictly more urgent than the handler currently running. An equal-priority request waits until that handler completes.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset no request is presented, and the enable, pending, priority and system words all read as zero. No handler is active.
- R2: A rising edge on peripheral line k sets pending bit k. So does a write of 1 to bit k at address 2. A write of 1 to bit k at address 3 clears it, and zero bits in either write change nothing. A line held high does not set the bit again. Reading address 2 returns the pending bits.
- R3: Writing 1s to address 0 sets enable bits and writing 1s to address 1 clears them. Reading address 0 returns the enables. A pending channel that is disabled is never presented, and it is presented as soon as it is enabled.
- R4: Channel k takes its priority from bits [2(k mod 16)+1 : 2(k mod 16)] of address 4 for channels 0 to 15, and of address 5 for channels 16 to 31. The supervisor-call priority sits in bits [1:0] of address 6. All of these read back. A lower value is more urgent, and between equal priorities the lower exception number wins.
- R5: The exception number is 2 for the non-maskable request, 3 for hard fault, 11 for supervisor call and 16+k for channel k. The vector output always equals four times the presented exception number.
- R6: A rising edge on the OR of the fault inputs pends the non-maskable request, and a rising edge on the hard-fault input pends hard fault. Neither depends on any enable bit. Both outrank every programmable level, and the non-maskable request outranks hard fault.
- R7: An acknowledge while a request is presented clears that request's pending flag and makes it the active handler from the next cycle. An acknowledge with nothing presented has no effect.
- R8: While a handler is active, a pending request is presented only if its priority is strictly more urgent than that handler's.
- R9: A completion pulse retires the innermost active handler. The next outer handler then becomes the reference for preemption again.
- R10: Reading address 6 also returns the non-maskable pending flag in bit 8, hard-fault pending in bit 9 and supervisor-call pending in bit 10. A supervisor-call request pends on a rising edge of its input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NCH | Peripheral interrupt lines, rising-edge sensitive |
| nmi_src | input | NNMI | Fault inputs merged into the non-maskable request |
| hf_in | input | 1 | Hard-fault request, rising-edge sensitive |
| svc_in | input | 1 | Supervisor-call request, rising-edge sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_valid | output | 1 | An exception is presented to the core |
| req_exc | output | EXC_W | Presented exception number |
| req_vec | output | EXC_W+2 | Byte address of the presented vector entry |
| core_ack | input | 1 | Core takes the presented exception |
| core_done | input | 1 | Core completes the innermost handler |

## Verification
The assertions assume that the core pulses completion only while a handler is active. The counting checks on the active set also assume that acknowledge and completion do not arrive in the same cycle. The non-maskable check assumes the fault inputs are not re-triggered while a non-maskable handler is already running. The bench keeps within these limits: every acknowledge is matched by exactly one later completion, the two pulses always fall in separate cycles, and the fault inputs are released before the next scenario. Register writes are one-cycle strobes driven on the falling edge, so the arbitration logic only ever sees settled state.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int PRIO_W = 2;
  localparam int NLVL   = 1 << PRIO_W;
  localparam int NKEY   = 2 + NLVL;
  localparam int KEY_W  = $clog2(NKEY + 1);
  localparam int AW     = 4;
  localparam int DW     = 32;

  typedef logic [KEY_W-1:0]  key_t;
  typedef logic [PRIO_W-1:0] prio_t;

  localparam key_t KEY_NMI  = key_t'(0);
  localparam key_t KEY_HF   = key_t'(1);
  localparam key_t KEY_IDLE = key_t'(NKEY);

  localparam int EXC_NMI  = 2;
  localparam int EXC_HF   = 3;
  localparam int EXC_SVC  = 11;
  localparam int EXC_BASE = 16;

  typedef enum logic [AW-1:0] {
    ADR_EN_SET = 4'd0,
    ADR_EN_CLR = 4'd1,
    ADR_PD_SET = 4'd2,
    ADR_PD_CLR = 4'd3,
    ADR_PRIO0  = 4'd4
  } reg_adr_e;

  // programmable levels sit below the two fixed system ranks
  function automatic key_t prio_key(prio_t p);
    return key_t'(p) + key_t'(2);
  endfunction

  function automatic key_t lowest_key(logic [NKEY-1:0] m);
    key_t r;
    r = KEY_IDLE;
    for (int i = NKEY - 1; i >= 0; i--) begin
      if (m[i]) r = key_t'(i);
    end
    return r;
  endfunction

  function automatic logic [NKEY-1:0] drop_lowest(logic [NKEY-1:0] m);
    return m & (m - 1'b1);
  endfunction

  function automatic logic [NKEY-1:0] key_bit(key_t k);
    return NKEY'(1) << k;
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_pkg::*;
#(
  parameter int NCH   = 32,
  parameter int NNMI  = 4,
  parameter int EXC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   irq_lines,
  input  logic [NNMI-1:0]  nmi_src,
  input  logic             hf_in,
  input  logic             svc_in,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             ack_fire,
  input  logic [EXC_W-1:0] ack_exc,
  output logic [NCH-1:0]   en_q,
  output logic [NCH-1:0]   pend_q,
  output prio_t            prio_q [NCH],
  output prio_t            svc_prio,
  output logic             nmi_pend,
  output logic             hf_pend,
  output logic             svc_pend
);
  localparam int NPW     = (NCH + 15) / 16;
  localparam int SYS_ADR = int'(ADR_PRIO0) + NPW;

  logic [NCH-1:0] lines_q;
  logic           nmi_q, hf_q, svc_q;
  logic           nmi_any;
  logic [NCH-1:0] line_rise;
  logic [NCH-1:0] pend_set, pend_clr;
  logic           wr_en_set, wr_en_clr, wr_pd_set, wr_pd_clr, wr_sys;
  logic           ack_nmi, ack_hf, ack_svc;

  assign nmi_any   = |nmi_src;
  assign line_rise = irq_lines & ~lines_q;

  assign wr_en_set = wr_en && (addr == ADR_EN_SET);
  assign wr_en_clr = wr_en && (addr == ADR_EN_CLR);
  assign wr_pd_set = wr_en && (addr == ADR_PD_SET);
  assign wr_pd_clr = wr_en && (addr == ADR_PD_CLR);
  assign wr_sys    = wr_en && (addr == AW'(SYS_ADR));

  assign ack_nmi = ack_fire && (ack_exc == EXC_W'(EXC_NMI));
  assign ack_hf  = ack_fire && (ack_exc == EXC_W'(EXC_HF));
  assign ack_svc = ack_fire && (ack_exc == EXC_W'(EXC_SVC));

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign pend_set[k] = line_rise[k] | (wr_pd_set & wdata[k]);
    assign pend_clr[k] = (wr_pd_clr & wdata[k]) |
                         (ack_fire && (ack_exc == EXC_W'(EXC_BASE + k)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lines_q  <= '0;
      nmi_q    <= 1'b0;
      hf_q     <= 1'b0;
      svc_q    <= 1'b0;
      en_q     <= '0;
      pend_q   <= '0;
      svc_prio <= '0;
      nmi_pend <= 1'b0;
      hf_pend  <= 1'b0;
      svc_pend <= 1'b0;
      for (int k = 0; k < NCH; k++) prio_q[k] <= '0;
    end else begin
      lines_q <= irq_lines;
      nmi_q   <= nmi_any;
      hf_q    <= hf_in;
      svc_q   <= svc_in;
      en_q    <= (en_q | (wr_en_set ? wdata[NCH-1:0] : '0)) &
                 ~(wr_en_clr ? wdata[NCH-1:0] : '0);
      pend_q  <= pend_set | (pend_q & ~pend_clr);
      nmi_pend <= (nmi_any & ~nmi_q) | (nmi_pend & ~ack_nmi);
      hf_pend  <= (hf_in & ~hf_q)    | (hf_pend & ~ack_hf);
      svc_pend <= (svc_in & ~svc_q)  | (svc_pend & ~ack_svc);
      if (wr_sys) svc_prio <= wdata[PRIO_W-1:0];
      for (int k = 0; k < NCH; k++) begin
        if (wr_en && (addr == AW'(int'(ADR_PRIO0) + k / 16)))
          prio_q[k] <= wdata[2*(k%16) +: PRIO_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADR_EN_SET) rdata[NCH-1:0] = en_q;
    if (addr == ADR_PD_SET) rdata[NCH-1:0] = pend_q;
    for (int w = 0; w < NPW; w++) begin
      if (addr == AW'(int'(ADR_PRIO0) + w)) begin
        for (int j = 0; j < 16; j++) begin
          if (w * 16 + j < NCH) rdata[2*j +: PRIO_W] = prio_q[w*16+j];
        end
      end
    end
    if (addr == AW'(SYS_ADR)) begin
      rdata[PRIO_W-1:0] = svc_prio;
      rdata[8]          = nmi_pend;
      rdata[9]          = hf_pend;
      rdata[10]         = svc_pend;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NCH   = 32,
  parameter int EXC_W = 6
) (
  input  logic [NCH-1:0]   live,
  input  prio_t            prio [NCH],
  input  logic             nmi_pend,
  input  logic             hf_pend,
  input  logic             svc_pend,
  input  prio_t            svc_prio,
  output logic             win_valid,
  output key_t             win_key,
  output logic [EXC_W-1:0] win_exc
);
  localparam int NSYS = 3;
  localparam int NSRC = NCH + NSYS;

  logic [NSRC-1:0]  c_vld;
  key_t             c_key [NSRC];
  logic [EXC_W-1:0] c_exc [NSRC];

  // candidate slots are ordered by ascending exception number
  assign c_vld[0] = nmi_pend;
  assign c_key[0] = KEY_NMI;
  assign c_exc[0] = EXC_W'(EXC_NMI);
  assign c_vld[1] = hf_pend;
  assign c_key[1] = KEY_HF;
  assign c_exc[1] = EXC_W'(EXC_HF);
  assign c_vld[2] = svc_pend;
  assign c_key[2] = prio_key(svc_prio);
  assign c_exc[2] = EXC_W'(EXC_SVC);

  for (genvar k = 0; k < NCH; k++) begin : g_slot
    assign c_vld[NSYS+k] = live[k];
    assign c_key[NSYS+k] = prio_key(prio[k]);
    assign c_exc[NSYS+k] = EXC_W'(EXC_BASE + k);
  end

  always_comb begin
    win_valid = 1'b0;
    win_key   = KEY_IDLE;
    win_exc   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (c_vld[i] && (c_key[i] < win_key)) begin
        win_valid = 1'b1;
        win_key   = c_key[i];
        win_exc   = c_exc[i];
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  key_t            push_key,
  input  logic            pop,
  output logic [NKEY-1:0] act_mask,
  output key_t            act_key
);
  logic [NKEY-1:0] mask_n;

  // strict preemption keeps active ranks distinct, so a bit set is enough
  always_comb begin
    mask_n = pop ? drop_lowest(act_mask) : act_mask;
    if (push) mask_n = mask_n | key_bit(push_key);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) act_mask <= '0;
    else        act_mask <= mask_n;
  end

  assign act_key = lowest_key(act_mask);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter  int NCH   = 32,
  parameter  int NNMI  = 4,
  localparam int EXC_W = $clog2(EXC_BASE + NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   irq_lines,
  input  logic [NNMI-1:0]  nmi_src,
  input  logic             hf_in,
  input  logic             svc_in,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             req_valid,
  output logic [EXC_W-1:0] req_exc,
  output logic [EXC_W+1:0] req_vec,
  input  logic             core_ack,
  input  logic             core_done
);
  logic [NCH-1:0]   en_q, pend_q, live;
  prio_t            prio_q [NCH];
  prio_t            svc_prio;
  logic             nmi_pend, hf_pend, svc_pend;
  logic             win_valid;
  key_t             win_key, act_key;
  logic [EXC_W-1:0] win_exc;
  logic [NKEY-1:0]  act_mask;
  logic             preempt_ok, ack_fire;

  irq_src_bank #(.NCH(NCH), .NNMI(NNMI), .EXC_W(EXC_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_lines(irq_lines),
    .nmi_src  (nmi_src),
    .hf_in    (hf_in),
    .svc_in   (svc_in),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .ack_fire (ack_fire),
    .ack_exc  (win_exc),
    .en_q     (en_q),
    .pend_q   (pend_q),
    .prio_q   (prio_q),
    .svc_prio (svc_prio),
    .nmi_pend (nmi_pend),
    .hf_pend  (hf_pend),
    .svc_pend (svc_pend)
  );

  assign live = pend_q & en_q;

  irq_arbiter #(.NCH(NCH), .EXC_W(EXC_W)) u_arb (
    .live     (live),
    .prio     (prio_q),
    .nmi_pend (nmi_pend),
    .hf_pend  (hf_pend),
    .svc_pend (svc_pend),
    .svc_prio (svc_prio),
    .win_valid(win_valid),
    .win_key  (win_key),
    .win_exc  (win_exc)
  );

  irq_nest_stack u_nest (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (ack_fire),
    .push_key(win_key),
    .pop     (core_done),
    .act_mask(act_mask),
    .act_key (act_key)
  );

  assign preempt_ok = win_key < act_key;
  assign req_valid  = win_valid && preempt_ok;
  assign ack_fire   = core_ack && req_valid;
  assign req_exc    = win_exc;
  assign req_vec    = {win_exc, 2'b00};
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_pkg::*;
#(
  parameter int NCH   = 32,
  parameter int EXC_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [EXC_W-1:0] req_exc,
  input key_t             win_key,
  input key_t             act_key,
  input logic [NKEY-1:0]  act_mask,
  input logic             ack_fire,
  input logic             core_ack,
  input logic             core_done,
  input logic [NCH-1:0]   en_q,
  input logic             nmi_pend
);
  localparam int IW = $clog2(NCH);

  AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (win_key < act_key)); // R8

  AST_MASKED_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_exc >= EXC_W'(EXC_BASE)) |-> en_q[IW'(req_exc - EXC_W'(EXC_BASE))]); // R3

  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && act_key != KEY_NMI) |-> (req_valid && req_exc == EXC_W'(EXC_NMI))); // R6

  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !core_done) |=> ($countones(act_mask) == $past($countones(act_mask)) + 1)); // R7

  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ack && !req_valid && !core_done) |=> $stable(act_mask)); // R7

  AST_DONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && !ack_fire && act_mask != '0) |=>
      ($countones(act_mask) + 1 == $past($countones(act_mask)))); // R9
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NCH(NCH), .EXC_W(EXC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_exc  (req_exc),
  .win_key  (win_key),
  .act_key  (act_key),
  .act_mask (act_mask),
  .ack_fire (ack_fire),
  .core_ack (core_ack),
  .core_done(core_done),
  .en_q     (en_q),
  .nmi_pend (nmi_pend)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int NCH   = 32;
  localparam int NNMI  = 4;
  localparam int EXC_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   irq_lines = '0;
  logic [NNMI-1:0]  nmi_src = '0;
  logic             hf_in = 1'b0, svc_in = 1'b0;
  logic             reg_wr = 1'b0;
  logic [3:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             req_valid;
  logic [EXC_W-1:0] req_exc;
  logic [EXC_W+1:0] req_vec;
  logic             core_ack = 1'b0, core_done = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl #(.NCH(NCH), .NNMI(NNMI)) dut (.*);

  typedef struct packed {
    logic [31:0] en;
    logic [31:0] pend;
    logic [31:0] plo;
    logic [31:0] phi;
    logic        vld;
    logic [5:0]  exc;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 1'b1, 6'd16},
    '{32'h0000_0006, 32'h0000_0006, 32'h0000_001C, 32'h0000_0000, 1'b1, 6'd18},
    '{32'hFFFF_FFFF, 32'h8000_0010, 32'hAAAA_AAAA, 32'h2AAA_AAAA, 1'b1, 6'd47},
    '{32'hFFFF_FFFF, 32'h0000_00A0, 32'h5555_5555, 32'h5555_5555, 1'b1, 6'd21},
    '{32'h0000_0001, 32'h0000_0002, 32'h0000_0000, 32'h0000_0000, 1'b0, 6'd0},
    '{32'h0000_0003, 32'h0000_0003, 32'h0000_000F, 32'h0000_0000, 1'b1, 6'd16},
    '{32'h0001_0000, 32'h0001_0001, 32'h0000_0000, 32'h0000_0000, 1'b1, 6'd32}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ack_pulse();
    @(negedge clk); core_ack = 1'b1;
    @(negedge clk); core_ack = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
  endtask

  task automatic expect_req(string tag, int exc);
    check({tag, " valid"}, 32'(req_valid), 32'd1);
    check({tag, " exc"}, 32'(req_exc), 32'(exc));
    check({tag, " vec"}, 32'(req_vec), 32'(exc * 4));
  endtask

  task automatic clean();
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd4, 32'h0);
    wr(4'd5, 32'h0);
    wr(4'd6, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 req_valid", 32'(req_valid), 32'd0);
    rd(4'd0, d); check("R1 enables", d, 32'd0);
    rd(4'd2, d); check("R1 pending", d, 32'd0);
    rd(4'd4, d); check("R1 prio lo", d, 32'd0);
    rd(4'd5, d); check("R1 prio hi", d, 32'd0);
    rd(4'd6, d); check("R1 sys word", d, 32'd0);

    // R4 R3 table of arbitration scenarios
    for (int i = 0; i < NV; i++) begin
      clean();
      wr(4'd4, TBL[i].plo);
      wr(4'd5, TBL[i].phi);
      wr(4'd0, TBL[i].en);
      wr(4'd2, TBL[i].pend);
      rd(4'd4, d); check("R4 prio lo readback", d, TBL[i].plo);
      check("R4/R3 table valid", 32'(req_valid), 32'(TBL[i].vld));
      if (TBL[i].vld) expect_req("R4 table", int'(TBL[i].exc));
    end

    // R2 edge set, clear write, held line
    clean();
    @(negedge clk); irq_lines[3] = 1'b1;
    @(negedge clk);
    rd(4'd2, d); check("R2 edge sets pending", d, 32'h8);
    wr(4'd3, 32'h0);
    rd(4'd2, d); check("R2 zero clear no effect", d, 32'h8);
    wr(4'd3, 32'h8);
    rd(4'd2, d); check("R2 clear with line held", d, 32'h0);
    irq_lines[3] = 1'b0;

    // R3 disabled pending channel waits for enable
    wr(4'd2, 32'h8);
    check("R3 disabled hidden", 32'(req_valid), 32'd0);
    wr(4'd0, 32'h8);
    expect_req("R3/R5 enabled", 19);
    wr(4'd1, 32'h8);
    rd(4'd0, d); check("R3 enable cleared", d, 32'h0);
    check("R3 hidden again", 32'(req_valid), 32'd0);

    // R7 acknowledge clears pending and activates
    wr(4'd0, 32'h8);
    wr(4'd4, 32'h0000_0680);
    ack_pulse();
    rd(4'd2, d); check("R7 ack clears pending", d, 32'h0);
    check("R7 nothing left", 32'(req_valid), 32'd0);

    // R8 strict preemption
    wr(4'd0, 32'h30);
    wr(4'd2, 32'h10);
    check("R8 equal waits", 32'(req_valid), 32'd0);
    wr(4'd2, 32'h20);
    expect_req("R8 higher preempts", 21);
    ack_pulse();
    check("R8 nested blocks", 32'(req_valid), 32'd0);
    // R9 completion unwinds
    done_pulse();
    check("R9 outer still blocks", 32'(req_valid), 32'd0);
    done_pulse();
    expect_req("R9 after outer done", 20);
    ack_pulse();
    done_pulse();
    check("R9 all retired", 32'(req_valid), 32'd0);

    // R7 acknowledge with nothing presented is ignored
    ack_pulse();
    wr(4'd2, 32'h8);
    expect_req("R7 stray ack ignored", 19);
    ack_pulse();
    done_pulse();

    // R6 R10 system exceptions
    clean();
    wr(4'd0, 32'h1);
    wr(4'd2, 32'h1);
    ack_pulse();
    wr(4'd1, 32'hFFFF_FFFF);
    @(negedge clk); nmi_src[2] = 1'b1; hf_in = 1'b1;
    @(negedge clk);
    expect_req("R6 nmi over all", 2);
    rd(4'd6, d); check("R10 sys pending bits", d, 32'h300);
    ack_pulse();
    check("R6 hf waits under nmi", 32'(req_valid), 32'd0);
    rd(4'd6, d); check("R10 nmi pending cleared", d, 32'h200);
    done_pulse();
    expect_req("R6 hard fault", 3);
    ack_pulse();
    done_pulse();
    done_pulse();
    nmi_src = '0; hf_in = 1'b0;
    check("R6 idle after faults", 32'(req_valid), 32'd0);

    // R4 R5 R10 supervisor call ordering
    clean();
    wr(4'd0, 32'h1);
    wr(4'd2, 32'h1);
    @(negedge clk); svc_in = 1'b1;
    @(negedge clk); svc_in = 1'b0;
    expect_req("R4/R5 svc wins tie", 11);
    rd(4'd6, d); check("R10 svc pending bit", d, 32'h400);
    wr(4'd6, 32'h1);
    expect_req("R4 svc demoted", 16);
    ack_pulse();
    done_pulse();
    expect_req("R4 svc after channel", 11);
    ack_pulse();
    done_pulse();
    check("R7 final idle", 32'(req_valid), 32'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule